// File: doc/BRIEF.md
# Exception entry and return controller

This block sits beside a processor pipeline and decides, every cycle, whether a pending exception, non-maskable interrupt or ordinary interrupt is taken. When one is taken it produces the write strobes and data for the saved-PC register and the saved-status register. It also produces the new status value with the block bit set. When the block bit is already set and a real fault arrives, it raises a manual reset instead and loads the exception-event code. On a return-from-exception strobe it produces the PC and status restore values. It then watches the single delay-slot cycle that follows, where the acceptance rules change.

Requests are level-held valid signals: `exc_valid`, `nmi_req` and `irq_req`. The block applies back-pressure through the registered `pending` output rather than through a ready handshake. A requester keeps its request and side information stable until it sees `take` with a matching `take_src`. It may withdraw the request at any time, and a withdrawn request is forgotten. All outputs are registered on the rising edge. Each decision is therefore visible one cycle after the inputs that caused it. The status block bit sits at bit `BL_BIT` (default 28) of `sr_in`.

Top module: `trap_ctrl`

## Requirements
- R1: During and right after synchronous reset, `take`, `pending`, `mreset`, `spc_we`, `ssr_we`, `sr_we` and `pc_load` are 0 and `expevt` is 0.
- R2: For an accepted re-execution exception (`exc_kind`=0), `spc_wd` is `cur_pc`, or `owner_pc` (the delayed branch's own PC) when `in_dslot` is 1, regardless of whether that branch was taken.
- R3: For an accepted completion exception (`exc_kind`=1, and also 3), a user break (`exc_kind`=2) or any interrupt, `spc_wd` is `seq_pc`, or `tgt_pc` when `is_dbranch` is 1.
- R4: On any acceptance, one cycle after the request `take`, `spc_we`, `ssr_we` and `sr_we` are 1. `ssr_wd` equals the `sr_in` of the request cycle, and `sr_wd` equals that value with bit `BL_BIT` set.
- R5: A re-execution or completion exception while the block bit is 1 gives `mreset`=1 and `expevt`=0x00000020, with no SPC, SSR or SR write and no `take`. A user break while the block bit is 1 is instead held pending.
- R6: An ordinary interrupt while the block bit is 1 (and not asleep) is held with `pending`=1. It is taken once the block bit reads 0.
- R7: An NMI while the block bit is 1 (and not asleep) is held pending when `nmi_blk_take`=0 and taken when `nmi_blk_take`=1.
- R8: With `sleep_mode`=1, an ordinary interrupt or an NMI is taken even when the block bit is 1.
- R9: Priority is exception, then NMI, then ordinary interrupt. `take_src` reports 0 for exception, 1 for NMI and 2 for interrupt. A lower request that is present but not taken makes `pending`=1.
- R10: One cycle after `rte_strobe`, `pc_load`=1 with `pc_wd`=`spc_in`, and `sr_we`=1 with `sr_wd`=`ssr_in`. Any request present in the strobe cycle is not taken and shows `pending`=1.
- R11: In the cycle after `rte_strobe` (the delay slot), a user break is not taken. An instruction-fetch exception (`exc_ifetch`=1) is judged against the block bit of the pre-return `sr_in`. Every other request is judged against the block bit of the restored `ssr_in`. A completion exception that passes is taken.
- R12: `pending` clears one cycle after an unaccepted request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception request held valid |
| exc_kind | input | 2 | 0 re-execution, 1 completion, 2 user break, 3 treated as completion |
| exc_ifetch | input | 1 | Exception comes from an instruction fetch |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Ordinary interrupt request |
| cur_pc | input | 32 | PC of the faulting instruction |
| seq_pc | input | 32 | PC of the next sequential instruction |
| tgt_pc | input | 32 | Destination of the delayed branch |
| owner_pc | input | 32 | PC of the branch owning the current delay slot |
| in_dslot | input | 1 | Current instruction sits in a delay slot |
| is_dbranch | input | 1 | Current instruction is a branch with a delay slot |
| sr_in | input | 32 | Current status register |
| sleep_mode | input | 1 | Core is asleep |
| nmi_blk_take | input | 1 | Take NMI even with block bit set |
| rte_strobe | input | 1 | Return-from-exception executes |
| spc_in | input | 32 | Current saved-PC register |
| ssr_in | input | 32 | Current saved-status register |
| take | output | 1 | A request was accepted |
| take_src | output | 2 | Source of accepted request |
| pending | output | 1 | Some request is held |
| mreset | output | 1 | Manual reset pulse |
| expevt | output | 32 | Exception-event code |
| spc_we | output | 1 | Saved-PC write enable |
| spc_wd | output | 32 | Saved-PC write data |
| ssr_we | output | 1 | Saved-status write enable |
| ssr_wd | output | 32 | Saved-status write data |
| sr_we | output | 1 | Status write enable |
| sr_wd | output | 32 | Status write data |
| pc_load | output | 1 | PC restore strobe |
| pc_wd | output | 32 | PC restore value |

## Verification
The return strobe and a new request can meet in one cycle. So can the delay slot that follows and a fault arriving in it. The bench raises an interrupt in the same cycle as `rte_strobe` and expects the restore outputs with the interrupt only pending. It then presents an instruction-fetch fault and a data fault in the delay slot after a return that changes the block bit from 0 to 1. The fetch fault must be taken and the data fault must give a manual reset. A second collision, an exception together with an NMI and an interrupt, is judged by `take_src` and by `pending` staying high until the last request is served.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    EXK_REEXEC = 2'd0,
    EXK_COMPL  = 2'd1,
    EXK_UBRK   = 2'd2,
    EXK_RSVD   = 2'd3
  } exc_kind_e;

  typedef enum logic [1:0] {
    SRC_EXC  = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_IRQ  = 2'd2,
    SRC_NONE = 2'd3
  } take_src_e;
endpackage

// File: rtl/trap_rte_track.sv
module trap_rte_track #(
  parameter int XLEN   = 32,
  parameter int BL_BIT = 28
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rte_strobe,
  input  logic [XLEN-1:0] sr_in,
  input  logic [XLEN-1:0] ssr_in,
  output logic            rte_ds,
  output logic            bl_old,
  output logic            bl_new
);
  // Remember both block bits across the return so the delay slot can pick.
  always_ff @(posedge clk) begin
    if (rst) begin
      rte_ds <= 1'b0;
      bl_old <= 1'b0;
      bl_new <= 1'b0;
    end else begin
      rte_ds <= rte_strobe;
      if (rte_strobe) begin
        bl_old <= sr_in[BL_BIT];
        bl_new <= ssr_in[BL_BIT];
      end
    end
  end

  // R11
  ds_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    rte_ds |-> $past(rte_strobe));
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic      exc_valid,
  input  exc_kind_e exc_kind,
  input  logic      exc_ifetch,
  input  logic      nmi_req,
  input  logic      irq_req,
  input  logic      bl_cur,
  input  logic      rte_ds,
  input  logic      bl_old,
  input  logic      bl_new,
  input  logic      sleep_mode,
  input  logic      nmi_blk_take,
  input  logic      rte_strobe,
  output logic      take,
  output take_src_e src,
  output logic      mreset,
  output logic      pend
);
  logic bl_exc, bl_int, nmi_blocked, irq_blocked;

  always_comb begin
    bl_exc      = rte_ds ? (exc_ifetch ? bl_old : bl_new) : bl_cur;
    bl_int      = rte_ds ? bl_new : bl_cur;
    nmi_blocked = bl_int && !sleep_mode && !nmi_blk_take;
    irq_blocked = bl_int && !sleep_mode;
  end

  always_comb begin
    take   = 1'b0;
    src    = SRC_NONE;
    mreset = 1'b0;
    pend   = 1'b0;
    if (rte_strobe) begin
      pend = exc_valid || nmi_req || irq_req;
    end else if (exc_valid) begin
      if (exc_kind == EXK_UBRK) begin
        if (rte_ds || bl_exc) begin
          pend = 1'b1;
        end else begin
          take = 1'b1;
          src  = SRC_EXC;
          pend = nmi_req || irq_req;
        end
      end else if (bl_exc) begin
        mreset = 1'b1;
        pend   = nmi_req || irq_req;
      end else begin
        take = 1'b1;
        src  = SRC_EXC;
        pend = nmi_req || irq_req;
      end
    end else if (nmi_req) begin
      if (nmi_blocked) begin
        pend = 1'b1;
      end else begin
        take = 1'b1;
        src  = SRC_NMI;
        pend = irq_req;
      end
    end else if (irq_req) begin
      if (irq_blocked) begin
        pend = 1'b1;
      end else begin
        take = 1'b1;
        src  = SRC_IRQ;
      end
    end
  end
endmodule

// File: rtl/trap_pc_sel.sv
module trap_pc_sel #(
  parameter int XLEN = 32
) (
  input  logic            reexec,
  input  logic            in_dslot,
  input  logic            is_dbranch,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] tgt_pc,
  input  logic [XLEN-1:0] owner_pc,
  output logic [XLEN-1:0] spc
);
  always_comb begin
    if (reexec) spc = in_dslot ? owner_pc : cur_pc;
    else        spc = is_dbranch ? tgt_pc : seq_pc;
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          BL_BIT    = 28,
  parameter logic [31:0] MR_EVCODE = 32'h0000_0020
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_valid,
  input  logic [1:0]      exc_kind,
  input  logic            exc_ifetch,
  input  logic            nmi_req,
  input  logic            irq_req,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] tgt_pc,
  input  logic [XLEN-1:0] owner_pc,
  input  logic            in_dslot,
  input  logic            is_dbranch,
  input  logic [XLEN-1:0] sr_in,
  input  logic            sleep_mode,
  input  logic            nmi_blk_take,
  input  logic            rte_strobe,
  input  logic [XLEN-1:0] spc_in,
  input  logic [XLEN-1:0] ssr_in,
  output logic            take,
  output logic [1:0]      take_src,
  output logic            pending,
  output logic            mreset,
  output logic [31:0]     expevt,
  output logic            spc_we,
  output logic [XLEN-1:0] spc_wd,
  output logic            ssr_we,
  output logic [XLEN-1:0] ssr_wd,
  output logic            sr_we,
  output logic [XLEN-1:0] sr_wd,
  output logic            pc_load,
  output logic [XLEN-1:0] pc_wd
);
  localparam logic [XLEN-1:0] BL_MASK = XLEN'(1) << BL_BIT;

  exc_kind_e       kind;
  logic            rte_ds, bl_old, bl_new;
  logic            a_take, a_mreset, a_pend;
  take_src_e       a_src;
  logic            reexec;
  logic [XLEN-1:0] spc_next;

  assign kind   = exc_kind_e'(exc_kind);
  assign reexec = (a_src == SRC_EXC) && (kind == EXK_REEXEC);

  trap_rte_track #(.XLEN(XLEN), .BL_BIT(BL_BIT)) u_rte (
    .clk(clk), .rst(rst), .rte_strobe(rte_strobe),
    .sr_in(sr_in), .ssr_in(ssr_in),
    .rte_ds(rte_ds), .bl_old(bl_old), .bl_new(bl_new)
  );

  trap_arbiter u_arb (
    .exc_valid(exc_valid), .exc_kind(kind), .exc_ifetch(exc_ifetch),
    .nmi_req(nmi_req), .irq_req(irq_req), .bl_cur(sr_in[BL_BIT]),
    .rte_ds(rte_ds), .bl_old(bl_old), .bl_new(bl_new),
    .sleep_mode(sleep_mode), .nmi_blk_take(nmi_blk_take),
    .rte_strobe(rte_strobe),
    .take(a_take), .src(a_src), .mreset(a_mreset), .pend(a_pend)
  );

  trap_pc_sel #(.XLEN(XLEN)) u_pcs (
    .reexec(reexec), .in_dslot(in_dslot), .is_dbranch(is_dbranch),
    .cur_pc(cur_pc), .seq_pc(seq_pc), .tgt_pc(tgt_pc),
    .owner_pc(owner_pc), .spc(spc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take     <= 1'b0;
      take_src <= SRC_NONE;
      pending  <= 1'b0;
      mreset   <= 1'b0;
      expevt   <= '0;
      spc_we   <= 1'b0;
      spc_wd   <= '0;
      ssr_we   <= 1'b0;
      ssr_wd   <= '0;
      sr_we    <= 1'b0;
      sr_wd    <= '0;
      pc_load  <= 1'b0;
      pc_wd    <= '0;
    end else begin
      take     <= a_take;
      take_src <= a_src;
      pending  <= a_pend;
      mreset   <= a_mreset;
      if (a_mreset) expevt <= MR_EVCODE;
      spc_we   <= a_take;
      ssr_we   <= a_take;
      sr_we    <= a_take || rte_strobe;
      pc_load  <= rte_strobe;
      if (a_take) begin
        spc_wd <= spc_next;
        ssr_wd <= sr_in;
        sr_wd  <= sr_in | BL_MASK;
      end else if (rte_strobe) begin
        sr_wd  <= ssr_in;
      end
      if (rte_strobe) pc_wd <= spc_in;
    end
  end

  // R4
  entry_writes_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> (spc_we && ssr_we && sr_we && sr_wd[BL_BIT]));

  // R5
  mreset_code_chk: assert property (@(posedge clk) disable iff (rst)
    mreset |-> (expevt == MR_EVCODE && !spc_we && !ssr_we && !sr_we));

  // R9
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take, mreset, pc_load}));

  // R10
  rte_restore_chk: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> ($past(rte_strobe) && sr_we && !take));

  // R6
  irq_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (take && take_src == SRC_IRQ) |-> ($past(irq_req) && !$past(exc_valid) && !$past(nmi_req)));

  // R11
  ds_no_ubrk_chk: assert property (@(posedge clk) disable iff (rst)
    (rte_ds && exc_valid && kind == EXK_UBRK) |=> !take);
endmodule

// File: tb/trap_ctrl_tb.sv
module trap_ctrl_tb;
  logic clk = 1'b0;
  logic rst;
  logic exc_valid, exc_ifetch, nmi_req, irq_req;
  logic [1:0] exc_kind;
  logic [31:0] cur_pc, seq_pc, tgt_pc, owner_pc, sr_in, spc_in, ssr_in;
  logic in_dslot, is_dbranch, sleep_mode, nmi_blk_take, rte_strobe;
  logic take, pending, mreset, spc_we, ssr_we, sr_we, pc_load;
  logic [1:0] take_src;
  logic [31:0] expevt, spc_wd, ssr_wd, sr_wd, pc_wd;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  localparam logic [31:0] BL = 32'h1000_0000;

  always #10 clk = ~clk;

  trap_ctrl u_dut (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_kind(exc_kind),
    .exc_ifetch(exc_ifetch), .nmi_req(nmi_req), .irq_req(irq_req),
    .cur_pc(cur_pc), .seq_pc(seq_pc), .tgt_pc(tgt_pc), .owner_pc(owner_pc),
    .in_dslot(in_dslot), .is_dbranch(is_dbranch), .sr_in(sr_in),
    .sleep_mode(sleep_mode), .nmi_blk_take(nmi_blk_take),
    .rte_strobe(rte_strobe), .spc_in(spc_in), .ssr_in(ssr_in),
    .take(take), .take_src(take_src), .pending(pending), .mreset(mreset),
    .expevt(expevt), .spc_we(spc_we), .spc_wd(spc_wd), .ssr_we(ssr_we),
    .ssr_wd(ssr_wd), .sr_we(sr_we), .sr_wd(sr_wd), .pc_load(pc_load),
    .pc_wd(pc_wd)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    exc_valid = 0; exc_kind = 0; exc_ifetch = 0; nmi_req = 0; irq_req = 0;
    in_dslot = 0; is_dbranch = 0; sleep_mode = 0; nmi_blk_take = 0;
    rte_strobe = 0;
    cur_pc = 32'h1000; seq_pc = 32'h1002; tgt_pc = 32'h3000;
    owner_pc = 32'h0FFE; sr_in = 32'h0000_00F0;
    spc_in = 32'h0; ssr_in = 32'h0;
  endtask

  // drive at negedge, one edge, sample at next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    idle();
    tick();
  endtask

  task automatic t_reset();
    chk("R1", "take", take, 0);
    chk("R1", "pending", pending, 0);
    chk("R1", "mreset", mreset, 0);
    chk("R1", "expevt", expevt, 0);
    chk("R1", "writes", {spc_we, ssr_we, sr_we, pc_load}, 0);
  endtask

  task automatic t_reexec();
    exc_valid = 1; exc_kind = 0; tick();
    chk("R2", "spc plain", spc_wd, 32'h1000);
    chk("R4", "take/src", {take, take_src}, {1'b1, 2'd0});
    chk("R4", "ssr_wd", ssr_wd, 32'h0000_00F0);
    chk("R4", "sr_wd", sr_wd, 32'h1000_00F0);
    chk("R4", "we", {spc_we, ssr_we, sr_we}, 3'b111);
    settle();
    exc_valid = 1; exc_kind = 0; in_dslot = 1; tick();
    chk("R2", "spc delay slot", spc_wd, 32'h0FFE);
    settle();
  endtask

  task automatic t_compl();
    exc_valid = 1; exc_kind = 1; tick();
    chk("R3", "spc seq", spc_wd, 32'h1002);
    settle();
    exc_valid = 1; exc_kind = 1; is_dbranch = 1; tick();
    chk("R3", "spc target", spc_wd, 32'h3000);
    settle();
    irq_req = 1; is_dbranch = 1; tick();
    chk("R3", "irq spc target", spc_wd, 32'h3000);
    settle();
    exc_valid = 1; exc_kind = 2; tick();
    chk("R3", "ubrk spc seq", spc_wd, 32'h1002);
    settle();
  endtask

  task automatic t_mreset();
    sr_in = BL | 32'hF0; exc_valid = 1; exc_kind = 0; tick();
    chk("R5", "mreset", mreset, 1);
    chk("R5", "expevt", expevt, 32'h20);
    chk("R5", "no writes", {take, spc_we, ssr_we, sr_we}, 0);
    settle();
    sr_in = BL; exc_valid = 1; exc_kind = 2; tick();
    chk("R5", "ubrk held", {mreset, take, pending}, 3'b001);
    settle();
  endtask

  task automatic t_irq_block();
    sr_in = BL; irq_req = 1; tick();
    chk("R6", "held", {take, pending}, 2'b01);
    sr_in = 32'h0; tick();
    chk("R6", "taken", {take, take_src, pending}, {1'b1, 2'd2, 1'b0});
    settle();
  endtask

  task automatic t_nmi_policy();
    sr_in = BL; nmi_req = 1; nmi_blk_take = 0; tick();
    chk("R7", "nmi held", {take, pending}, 2'b01);
    nmi_blk_take = 1; tick();
    chk("R7", "nmi taken", {take, take_src}, {1'b1, 2'd1});
    settle();
  endtask

  task automatic t_sleep();
    sr_in = BL; sleep_mode = 1; irq_req = 1; tick();
    chk("R8", "irq in sleep", {take, take_src}, {1'b1, 2'd2});
    settle();
    sr_in = BL; sleep_mode = 1; nmi_req = 1; tick();
    chk("R8", "nmi in sleep", {take, take_src}, {1'b1, 2'd1});
    settle();
  endtask

  task automatic t_priority();
    exc_valid = 1; exc_kind = 1; nmi_req = 1; irq_req = 1; tick();
    chk("R9", "exc first", {take, take_src, pending}, {1'b1, 2'd0, 1'b1});
    exc_valid = 0; tick();
    chk("R9", "nmi next", {take, take_src, pending}, {1'b1, 2'd1, 1'b1});
    nmi_req = 0; tick();
    chk("R9", "irq last", {take, take_src, pending}, {1'b1, 2'd2, 1'b0});
    settle();
  endtask

  task automatic t_rte();
    rte_strobe = 1; spc_in = 32'h4000; ssr_in = 32'h55; irq_req = 1; tick();
    chk("R10", "pc restore", {pc_load, pc_wd}, {1'b1, 32'h4000});
    chk("R10", "sr restore", {sr_we, sr_wd}, {1'b1, 32'h55});
    chk("R10", "irq held", {take, pending}, 2'b01);
    settle();
  endtask

  task automatic rte_then(input logic [31:0] restored);
    rte_strobe = 1; sr_in = 32'h0; ssr_in = restored; spc_in = 32'h5000; tick();
    rte_strobe = 0;
  endtask

  task automatic t_rte_ds();
    rte_then(BL);
    exc_valid = 1; exc_kind = 1; exc_ifetch = 1; tick();
    chk("R11", "ifetch vs old sr", {take, mreset}, 2'b10);
    settle();
    rte_then(BL);
    exc_valid = 1; exc_kind = 1; exc_ifetch = 0; tick();
    chk("R11", "data vs new sr", {take, mreset}, 2'b01);
    settle();
    rte_then(32'h0);
    exc_valid = 1; exc_kind = 2; tick();
    chk("R11", "ubrk in slot", {take, pending}, 2'b01);
    settle();
    rte_then(32'h0);
    exc_valid = 1; exc_kind = 1; tick();
    chk("R11", "completion in slot", {take, take_src}, {1'b1, 2'd0});
    settle();
  endtask

  task automatic t_withdraw();
    sr_in = BL; irq_req = 1; tick();
    chk("R12", "held", pending, 1);
    irq_req = 0; tick();
    chk("R12", "withdrawn", {pending, take}, 2'b00);
    settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    tick();
    t_reset();
    t_reexec();
    t_compl();
    t_mreset();
    t_irq_block();
    t_nmi_policy();
    t_sleep();
    t_priority();
    t_rte();
    t_rte_ds();
    t_withdraw();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule